// File: doc/BRIEF.md
# Conditional-Sum Adder

This block adds two unsigned operands of `WIDTH` bits and a carry-in with no clock, using carry selection applied recursively down to single bits. Each bit position first forms two candidate results, a carry and a sum for an incoming carry of 0 and for an incoming carry of 1. Over log2 `WIDTH` merge levels, neighbouring groups are paired. The merged group keeps the low group's sum unchanged. The low group's carry-out, under the same assumed carry, chooses one of the high group's two candidates.

Both candidate branches are kept through every level. At the top, the real carry-in chooses between the two complete results. The block is a drop-in replacement for a ripple adder wherever the carry chain sets the timing. Its delay grows with the number of merge levels instead of with the operand width.

Top module: `csum_adder`

## Requirements
- R1: For every pair of operands and either carry-in, `{co, sum}` equals `a + b + ci` computed at `WIDTH+1` bits.
- R2: With both operands all ones and `ci` = 1, `sum` is all ones and `co` is 1.
- R3: With both operands zero, `sum` equals `ci` zero-extended and `co` is 0.
- R4: With `b` the bitwise complement of `a`, `ci` = 0 gives `sum` all ones and `co` = 0, and `ci` = 1 gives `sum` zero and `co` = 1.
- R5: For the same operands, the `{co, sum}` result with `ci` = 1 equals the result with `ci` = 0 plus one, modulo 2^(`WIDTH`+1).
- R6: A carry generated in bit 0 (`a` = 1, `b` all ones, `ci` = 0) ripples to the top: `sum` is zero and `co` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| co | output | 1 | Carry out of the top bit |

## Verification
The two things that meet in one evaluation are the candidate-carry selection inside the merge tree and the final choice made by the real carry-in. They interact hardest when a carry must pass through every level. The bench provokes this with complementary operands, with all-ones operands and with a carry generated in bit 0. It applies each such vector under both carry-in values and compares the pair, so the result must show the two branches exactly one apart. Random operand pairs then judge the general case against a plain integer sum.

// File: rtl/csum_adder.sv
module csum_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             co
);
  localparam int LEVELS = $clog2(WIDTH);

  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int GW = 1 << l;
    localparam int NG = WIDTH >> l;
    logic [WIDTH-1:0] s0, s1;
    logic [NG-1:0]    c0, c1;

    if (l == 0) begin : g_leaf
      assign s0 = a ^ b;
      assign s1 = ~(a ^ b);
      assign c0 = a & b;
      assign c1 = a | b;
    end else begin : g_merge
      localparam int HW = GW / 2;
      for (genvar g = 0; g < NG; g++) begin : grp
        localparam int LO = 2 * g;
        localparam int HI = 2 * g + 1;
        localparam int BASE = g * GW;
        logic sel0, sel1;
        assign sel0 = lvl[l-1].c0[LO];
        assign sel1 = lvl[l-1].c1[LO];
        assign s0[BASE +: HW] = lvl[l-1].s0[BASE +: HW];
        assign s1[BASE +: HW] = lvl[l-1].s1[BASE +: HW];
        assign s0[BASE+HW +: HW] = sel0 ? lvl[l-1].s1[BASE+HW +: HW] : lvl[l-1].s0[BASE+HW +: HW];
        assign s1[BASE+HW +: HW] = sel1 ? lvl[l-1].s1[BASE+HW +: HW] : lvl[l-1].s0[BASE+HW +: HW];
        assign c0[g] = sel0 ? lvl[l-1].c1[HI] : lvl[l-1].c0[HI];
        assign c1[g] = sel1 ? lvl[l-1].c1[HI] : lvl[l-1].c0[HI];
      end
    end

    // R5
    always_comb begin
      carry_order_chk : assert ((c0 & ~c1) == '0)
        else $error("assumed-0 carry set while assumed-1 carry clear at level %0d", l);
    end
  end

  assign sum = ci ? lvl[LEVELS].s1 : lvl[LEVELS].s0;
  assign co  = ci ? lvl[LEVELS].c1[0] : lvl[LEVELS].c0[0];

  always_comb begin
    // R5
    branch_step_chk : assert ({lvl[LEVELS].c1[0], lvl[LEVELS].s1} ==
                              {lvl[LEVELS].c0[0], lvl[LEVELS].s0} + 1'b1)
      else $error("carry-in branches not one apart");
    // R3
    if (a == '0 && b == '0)
      zero_operand_chk : assert ({co, sum} == {{WIDTH{1'b0}}, ci})
        else $error("zero operands gave wrong result");
    // R4
    if (b == ~a)
      full_propagate_chk : assert ({co, sum} == (ci ? {1'b1, {WIDTH{1'b0}}} : {1'b0, {WIDTH{1'b1}}}))
        else $error("complementary operands gave wrong result");
    // R2
    if (a == '1 && b == '1 && ci)
      all_ones_chk : assert ({co, sum} == {1'b1, {WIDTH{1'b1}}})
        else $error("all-ones operands gave wrong result");
  end
endmodule

// File: tb/test_csum_adder.sv
module test_csum_adder;
  localparam int WIDTH = 16;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WIDTH-1:0] a = '0, b = '0;
  logic ci = 1'b0;
  logic [WIDTH-1:0] sum;
  logic co;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csum_adder #(.WIDTH(WIDTH)) i_csum_adder (
    .a(a), .b(b), .ci(ci), .sum(sum), .co(co)
  );

  function automatic logic [WIDTH:0] ref_add(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c};
  endfunction

  task automatic compare(string req, logic [WIDTH:0] got, logic [WIDTH:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: a=%h b=%h ci=%0d actual=%h expected=%h", req, a, b, ci, got, exp);
    end
  endtask

  task automatic apply(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c, output logic [WIDTH:0] res);
    @(negedge clk);
    a = x; b = y; ci = c;
    @(posedge clk);
    #1;
    res = {co, sum};
  endtask

  task automatic pair(string req, logic [WIDTH-1:0] x, logic [WIDTH-1:0] y);
    logic [WIDTH:0] r0, r1;
    apply(x, y, 1'b0, r0);
    compare({req, "/R1"}, r0, ref_add(x, y, 1'b0));
    apply(x, y, 1'b1, r1);
    compare({req, "/R1"}, r1, ref_add(x, y, 1'b1));
    compare("R5", r1, r0 + 1'b1);
  endtask

  initial begin
    logic [WIDTH:0] r;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1;
    compare("R3 reset", {co, sum}, '0);
    rst_n = 1'b1;

    apply('0, '0, 1'b1, r);
    compare("R3", r, {{WIDTH{1'b0}}, 1'b1});
    apply('0, '0, 1'b0, r);
    compare("R3", r, '0);
    apply('1, '1, 1'b1, r);
    compare("R2", r, {1'b1, {WIDTH{1'b1}}});
    apply(16'h00ff, 16'hff00, 1'b0, r);
    compare("R4", r, {1'b0, {WIDTH{1'b1}}});
    apply(16'h00ff, 16'hff00, 1'b1, r);
    compare("R4", r, {1'b1, {WIDTH{1'b0}}});
    apply(16'h5a5a, 16'ha5a5, 1'b1, r);
    compare("R4", r, {1'b1, {WIDTH{1'b0}}});
    apply(16'h0001, '1, 1'b0, r);
    compare("R6", r, {1'b1, {WIDTH{1'b0}}});

    pair("R2", '1, '1);
    pair("R4", 16'h1234, ~16'h1234);
    pair("R6", 16'h0001, '1);
    pair("R1", 16'h8000, 16'h8000);
    pair("R1", 16'h7fff, 16'h0001);

    for (int i = 0; i < 1500; i++) begin
      logic [WIDTH-1:0] x, y;
      x = WIDTH'($urandom);
      y = WIDTH'($urandom);
      if (i % 5 == 0) y = ~x ^ WIDTH'(1 << (i % WIDTH));
      pair("R1", x, y);
    end
    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule